// File: doc/BRIEF.md
# Flash Status Polling Controller

This block models the control and status side of a byte-wide parallel NOR-style flash array as seen from an 8-bit microcontroller bus. Software writes multi-byte unlock sequences to fixed command addresses. A full program sequence starts a timed program of one byte. A full erase sequence starts a timed bulk erase of every unprotected sector. While an operation is running, every selected read returns a status byte instead of array data. Bit 7 of that byte is a data-polling flag and bit 6 is a toggle flag. Software polls either flag until the operation has ended.

The array is organised as `NSECT` sectors of `2**BYTE_AW` bytes each. A one-hot sector select input picks the sector. The low `BYTE_AW` address bits pick the byte within it. The cell array is a small register memory. Its timing is reduced to cycle counts given as parameters, and a per-sector protect vector blocks erasure.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset `busy` is 0, `rdata` is 00h, the controller is in array-read mode, and every stored byte reads FFh.
- R2: A read or write is taken only when some bit of `sect_sel` is 1. The lowest set bit gives the sector index. The byte index is sector index * 2**BYTE_AW + `addr[BYTE_AW-1:0]`. A read with no sector selected leaves `rdata` and the toggle flag unchanged, and a write with no sector selected has no effect.
- R3: Writing AAh to 555h, then 55h to 2AAh, then A0h to 555h, then a data byte D to any address starts a program. `busy` is 1 for exactly PROG_CYC cycles, starting the cycle after the fourth write. Afterwards the addressed byte holds its old value AND D.
- R4: A status read during a program returns the complement of D bit 7 in bit 7.
- R5: Writing AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, then 30h to any address starts a bulk erase if at least one `prot` bit is 0. `busy` is 1 for ERASE_CYC cycles. Status bit 7 reads 0 during the erase. Afterwards every byte of every sector whose `prot` bit was 0 at the start reads FFh, and bytes in protected sectors are unchanged.
- R6: Every selected read while `busy` is 1 returns bit 6 equal to a toggle flag, which then inverts. The flag is 0 after reset and persists across operations. Bits 5..0 of a status byte are 0.
- R7: Once `busy` has fallen, reads return stored data again, so two successive reads of the same byte return the same bit 6.
- R8: If all `prot` bits are 1, a completed erase sequence makes `busy` 1 for LOCK_CYC cycles with status bit 7 = 0, and no byte changes.
- R9: Any write that does not match the next expected step returns the decoder to idle, with no operation started. This includes F0h at any step other than the program data step.
- R10: Writes taken while `busy` is 1 are ignored entirely: they start no operation and do not advance a sequence.
- R11: `rdata` changes only in the cycle after a selected read is sampled, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sect_sel | input | NSECT | One-hot sector select; all zero means not selected |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte address, low 12 bits used for command decode |
| wdata | input | 8 | Write data |
| prot | input | NSECT | Per-sector erase protection, 1 = protected |
| rdata | output | 8 | Read data or status byte, registered |
| busy | output | 1 | High while a program, erase or protected-erase interval runs |

## Verification
A read sampled at clock edge N shows its data or status byte in `rdata` right after that edge. The bench drives the strobe for one cycle and samples at the next falling edge. Whether a read returns status depends on `busy` as it was before that edge, so the bench records `busy` when it drives the read and computes the expected byte from that value. `busy` rises right after the edge that samples the final write of a sequence, and it stays high for exactly the configured cycle count. A falling-edge counter measures that length and compares it with the parameter. Array contents are checked only after `busy` has fallen. The expected values come from a bench model of the memory and the toggle flag.

// File: rtl/flash_poll_pkg.sv
// Package: shared types and command constants of the flash status polling
// controller. Assumes 12-bit command decode addresses.
package flash_poll_pkg;

    localparam logic [11:0] ADR_UNLOCK_A = 12'h555;
    localparam logic [11:0] ADR_UNLOCK_B = 12'h2AA;

    localparam logic [7:0] CMD_KEY_A    = 8'hAA;
    localparam logic [7:0] CMD_KEY_B    = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_ERASE_GO = 8'h30;
    localparam logic [7:0] CMD_RESET    = 8'hF0;

    // Operating mode of the array
    typedef enum logic [1:0] {
        M_ARRAY  = 2'd0,   // normal array reads
        M_PROG   = 2'd1,   // program in progress
        M_ERASE  = 2'd2,   // bulk erase in progress
        M_LOCKED = 2'd3    // erase refused, fixed busy interval
    } mode_t;

    // Position within a command sequence
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_KEY1  = 3'd1,
        S_KEY2  = 3'd2,
        S_PDATA = 3'd3,
        S_EKEY0 = 3'd4,
        S_EKEY1 = 3'd5,
        S_EKEY2 = 3'd6
    } step_t;

endpackage

// File: rtl/fpc_cmd_seq.sv
// Command sequence decoder. Tracks the unlock steps of program and erase
// sequences and pulses a launch output when a sequence completes.
// Assumes wr is already qualified by sector select and not-busy.
module fpc_cmd_seq
    import flash_poll_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [11:0] cmd_addr,
    input  logic [7:0]  cmd_data,
    output logic        launch_prog,
    output logic        launch_erase
);

    step_t step_q;

    logic hit_a;
    logic hit_b;

    // Purpose: match the two unlock key writes
    always_comb begin
        hit_a = (cmd_addr == ADR_UNLOCK_A) && (cmd_data == CMD_KEY_A);
        hit_b = (cmd_addr == ADR_UNLOCK_B) && (cmd_data == CMD_KEY_B);
    end

    // Purpose: advance or abandon the sequence on each accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= S_IDLE;
        end else if (wr) begin
            if (cmd_data == CMD_RESET && step_q != S_PDATA) begin
                step_q <= S_IDLE;
            end else begin
                case (step_q)
                    S_IDLE:  step_q <= hit_a ? S_KEY1 : S_IDLE;
                    S_KEY1:  step_q <= hit_b ? S_KEY2 : S_IDLE;
                    S_KEY2: begin
                        if (cmd_addr == ADR_UNLOCK_A && cmd_data == CMD_PROGRAM)
                            step_q <= S_PDATA;
                        else if (cmd_addr == ADR_UNLOCK_A && cmd_data == CMD_ERASE)
                            step_q <= S_EKEY0;
                        else
                            step_q <= S_IDLE;
                    end
                    S_EKEY0: step_q <= hit_a ? S_EKEY1 : S_IDLE;
                    S_EKEY1: step_q <= hit_b ? S_EKEY2 : S_IDLE;
                    default: step_q <= S_IDLE;
                endcase
            end
        end
    end

    // Purpose: raise launch pulses on the final write of a sequence
    always_comb begin
        launch_prog  = wr && (step_q == S_PDATA);
        launch_erase = wr && (step_q == S_EKEY2) && (cmd_data == CMD_ERASE_GO);
    end

endmodule

// File: rtl/fpc_op_engine.sv
// Operation engine. Holds the operating mode, counts the busy interval of
// program, erase and refused erase, and keeps the read toggle flag.
// Assumes launches arrive only in array mode and all cycle counts >= 1.
module fpc_op_engine
    import flash_poll_pkg::*;
#(
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 40,
    parameter int LOCK_CYC  = 12
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  launch_prog,
    input  logic  launch_erase,
    input  logic  all_prot,
    input  logic  status_rd,
    output mode_t mode,
    output logic  busy,
    output logic  done_prog,
    output logic  done_erase,
    output logic  tog
);

    localparam int MAXC = (PROG_CYC > ERASE_CYC) ?
                          ((PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC) :
                          ((ERASE_CYC > LOCK_CYC) ? ERASE_CYC : LOCK_CYC);
    localparam int CW = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    // Purpose: mode transitions and the busy countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= M_ARRAY;
            cnt_q <= '0;
        end else if (mode == M_ARRAY) begin
            if (launch_prog) begin
                mode  <= M_PROG;
                cnt_q <= CW'(PROG_CYC - 1);
            end else if (launch_erase) begin
                mode  <= all_prot ? M_LOCKED : M_ERASE;
                cnt_q <= all_prot ? CW'(LOCK_CYC - 1) : CW'(ERASE_CYC - 1);
            end
        end else if (cnt_q == '0) begin
            mode <= M_ARRAY;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: invert the toggle flag on each status read
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog <= 1'b0;
        else if (status_rd)
            tog <= ~tog;
    end

    // Purpose: decode busy and completion strobes
    always_comb begin
        busy       = (mode != M_ARRAY);
        done_prog  = (mode == M_PROG)  && (cnt_q == '0);
        done_erase = (mode == M_ERASE) && (cnt_q == '0);
    end

endmodule

// File: rtl/fpc_store.sv
// Register-based byte store. Resets to the erased value FFh, applies
// AND-programming of one byte and bulk erase under a sector mask.
// Assumes program and erase strobes are never raised together.
module fpc_store #(
    parameter int NSECT   = 4,
    parameter int BYTE_AW = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           prog_we,
    input  logic [$clog2(NSECT)+BYTE_AW-1:0] prog_idx,
    input  logic [7:0]                     prog_byte,
    input  logic                           erase_we,
    input  logic [NSECT-1:0]               erase_mask,
    input  logic [$clog2(NSECT)+BYTE_AW-1:0] rd_idx,
    output logic [7:0]                     rd_byte
);

    localparam int DEPTH = NSECT << BYTE_AW;

    logic [7:0] mem [DEPTH];

    // Purpose: reset, program and erase the stored bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (prog_we) begin
            mem[prog_idx] <= mem[prog_idx] & prog_byte;
        end else if (erase_we) begin
            for (int i = 0; i < DEPTH; i++)
                if (erase_mask[i >> BYTE_AW]) mem[i] <= 8'hFF;
        end
    end

    // Purpose: asynchronous read port
    assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/flash_poll_ctrl.sv
// Top level of the flash status polling controller. Qualifies bus strobes
// with the sector select, latches the program target and the erase mask,
// and drives the registered read data: stored byte or polling status.
// Assumes sect_sel is one-hot (lowest set bit wins) and NSECT >= 2.
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int NSECT     = 4,
    parameter int BYTE_AW   = 4,
    parameter int ADDR_W    = 12,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 40,
    parameter int LOCK_CYC  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSECT-1:0]  sect_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [NSECT-1:0]  prot,
    output logic [7:0]        rdata,
    output logic              busy
);

    localparam int SW    = $clog2(NSECT);
    localparam int IDX_W = SW + BYTE_AW;

    logic             selected;
    logic [SW-1:0]    sect_idx;
    logic [IDX_W-1:0] byte_idx;
    logic             wr_ok;
    logic             rd_ok;
    logic             status_rd;
    logic             launch_prog;
    logic             launch_erase;
    logic             done_prog;
    logic             done_erase;
    logic             tog;
    mode_t            mode;
    logic [IDX_W-1:0] tgt_idx_q;
    logic [7:0]       tgt_byte_q;
    logic [NSECT-1:0] erase_mask_q;
    logic [7:0]       rd_byte;
    logic             st_bit7;

    // Purpose: sector index from the select vector, lowest bit wins
    always_comb begin
        sect_idx = '0;
        for (int s = NSECT - 1; s >= 0; s--)
            if (sect_sel[s]) sect_idx = SW'(s);
    end

    // Purpose: qualify strobes and form the byte index
    always_comb begin
        selected  = |sect_sel;
        byte_idx  = {sect_idx, addr[BYTE_AW-1:0]};
        wr_ok     = wr_en && selected && !busy;
        rd_ok     = rd_en && selected;
        status_rd = rd_ok && busy;
    end

    fpc_cmd_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (wr_ok),
        .cmd_addr     (addr[11:0]),
        .cmd_data     (wdata),
        .launch_prog  (launch_prog),
        .launch_erase (launch_erase)
    );

    fpc_op_engine #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC),
        .LOCK_CYC  (LOCK_CYC)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_prog  (launch_prog),
        .launch_erase (launch_erase),
        .all_prot     (&prot),
        .status_rd    (status_rd),
        .mode         (mode),
        .busy         (busy),
        .done_prog    (done_prog),
        .done_erase   (done_erase),
        .tog          (tog)
    );

    // Purpose: capture program target and erase mask at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_idx_q    <= '0;
            tgt_byte_q   <= 8'hFF;
            erase_mask_q <= '0;
        end else begin
            if (launch_prog) begin
                tgt_idx_q  <= byte_idx;
                tgt_byte_q <= wdata;
            end
            if (launch_erase) erase_mask_q <= ~prot;
        end
    end

    fpc_store #(
        .NSECT   (NSECT),
        .BYTE_AW (BYTE_AW)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_we    (done_prog),
        .prog_idx   (tgt_idx_q),
        .prog_byte  (tgt_byte_q),
        .erase_we   (done_erase),
        .erase_mask (erase_mask_q),
        .rd_idx     (byte_idx),
        .rd_byte    (rd_byte)
    );

    // Purpose: data-polling bit, complement while programming, else 0
    assign st_bit7 = (mode == M_PROG) ? ~tgt_byte_q[7] : 1'b0;

    // Purpose: register read data or status byte on each selected read
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (rd_ok)
            rdata <= busy ? {st_bit7, tog, 6'b000000} : rd_byte;
    end

endmodule

// File: rtl/fpc_checker.sv
// Assertion checker for flash_poll_ctrl, attached by bind below.
// Relates bus strobes, busy, mode and read data over time.
module fpc_checker
    import flash_poll_pkg::*;
#(
    parameter int NSECT     = 4,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 40,
    parameter int LOCK_CYC  = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSECT-1:0] sect_sel,
    input logic             rd_en,
    input logic [7:0]       rdata,
    input logic             busy,
    input mode_t            mode,
    input logic             tgt_bit7,
    input logic             launch_prog,
    input logic             launch_erase,
    input logic             tog
);

    localparam int MAXC = (PROG_CYC > ERASE_CYC) ?
                          ((PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC) :
                          ((ERASE_CYC > LOCK_CYC) ? ERASE_CYC : LOCK_CYC);

    logic        st_q;
    logic        seen_q;
    logic        prev_b6_q;
    logic [15:0] busy_len_q;

    // Purpose: track status reads and the length of the busy window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= 1'b0;
            seen_q     <= 1'b0;
            prev_b6_q  <= 1'b0;
            busy_len_q <= '0;
        end else begin
            st_q       <= rd_en && (|sect_sel) && busy;
            busy_len_q <= busy ? busy_len_q + 1'b1 : '0;
            if (st_q) begin
                seen_q    <= 1'b1;
                prev_b6_q <= rdata[6];
            end
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !busy);

    a_r4_prog_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (|sect_sel) && mode == M_PROG) |-> rdata[7] == !$past(tgt_bit7));

    a_r5_erase_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (|sect_sel) && mode == M_ERASE) |-> !rdata[7]);

    a_r8_locked_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (|sect_sel) && mode == M_LOCKED) |-> !rdata[7]);

    a_r6_bit6_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q && seen_q) |-> rdata[6] != prev_b6_q);

    a_r2_unselected_keeps_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(|sect_sel)) |=> $stable(tog));

    a_r10_no_launch_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(launch_prog || launch_erase));

    a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len_q <= 16'(MAXC));

    a_r11_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));

endmodule

bind flash_poll_ctrl fpc_checker #(
    .NSECT     (NSECT),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .LOCK_CYC  (LOCK_CYC)
) i_fpc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sect_sel     (sect_sel),
    .rd_en        (rd_en),
    .rdata        (rdata),
    .busy         (busy),
    .mode         (mode),
    .tgt_bit7     (tgt_byte_q[7]),
    .launch_prog  (launch_prog),
    .launch_erase (launch_erase),
    .tog          (tog)
);

// File: tb/test_flash_poll_ctrl.sv
module test_flash_poll_ctrl;

    localparam int NSECT     = 4;
    localparam int BYTE_AW   = 4;
    localparam int PROG_CYC  = 20;
    localparam int ERASE_CYC = 40;
    localparam int LOCK_CYC  = 12;
    localparam int DEPTH     = NSECT << BYTE_AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSECT-1:0] sect_sel = '0;
    logic             rd_en = 1'b0;
    logic             wr_en = 1'b0;
    logic [11:0]      addr = '0;
    logic [7:0]       wdata = '0;
    logic [NSECT-1:0] prot = '0;
    logic [7:0]       rdata;
    logic             busy;

    int   checks = 0;
    int   errors = 0;
    int   busy_cnt = 0;
    logic [7:0] model [DEPTH];
    logic tog_m = 1'b0;

    always #2.5 clk = ~clk;

    flash_poll_ctrl #(
        .NSECT(NSECT), .BYTE_AW(BYTE_AW), .ADDR_W(12),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .LOCK_CYC(LOCK_CYC)
    ) i_flash_poll_ctrl (
        .clk(clk), .rst_n(rst_n), .sect_sel(sect_sel), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .prot(prot),
        .rdata(rdata), .busy(busy)
    );

    // busy length measured at falling edges
    always @(negedge clk) if (busy) busy_cnt++;

    function automatic int idx_of(input logic [NSECT-1:0] s, input logic [11:0] a);
        int k = 0;
        for (int i = NSECT - 1; i >= 0; i--) if (s[i]) k = i;
        return (k << BYTE_AW) + int'(a[BYTE_AW-1:0]);
    endfunction

    function automatic logic [7:0] status_byte(input logic b7, input logic b6);
        return {b7, b6, 6'b000000};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [NSECT-1:0] s, input logic [11:0] a, input logic [7:0] d);
        sect_sel = s; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sect_sel = '0;
    endtask

    task automatic rd(input logic [NSECT-1:0] s, input logic [11:0] a,
                      output logic [7:0] v, output logic was_busy);
        was_busy = busy;
        sect_sel = s; addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; sect_sel = '0;
        v = rdata;
    endtask

    // read while busy expected: status byte with model toggle
    task automatic status_read(input string req, input logic [NSECT-1:0] s, input logic b7);
        logic [7:0] v; logic wb;
        rd(s, 12'h0, v, wb);
        if (wb) begin
            check(req, v, status_byte(b7, tog_m));
            tog_m = ~tog_m;
        end
    endtask

    task automatic array_read(input string req, input logic [NSECT-1:0] s, input logic [11:0] a);
        logic [7:0] v; logic wb;
        rd(s, a, v, wb);
        check(req, v, model[idx_of(s, a)]);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic program_op(input logic [NSECT-1:0] s, input logic [11:0] a,
                              input logic [7:0] d, input int nreads);
        busy_cnt = 0;
        wr(s, 12'h555, 8'hAA);
        wr(s, 12'h2AA, 8'h55);
        wr(s, 12'h555, 8'hA0);
        wr(s, a, d);
        check("R3 busy after program launch", busy, 1'b1);
        for (int i = 0; i < nreads; i++) status_read("R4 R6 program status", s, ~d[7]);
        wait_idle();
        check("R3 program busy length", busy_cnt, PROG_CYC);
        model[idx_of(s, a)] = model[idx_of(s, a)] & d;
    endtask

    task automatic erase_seq(input logic [NSECT-1:0] s);
        busy_cnt = 0;
        wr(s, 12'h555, 8'hAA);
        wr(s, 12'h2AA, 8'h55);
        wr(s, 12'h555, 8'h80);
        wr(s, 12'h555, 8'hAA);
        wr(s, 12'h2AA, 8'h55);
        wr(s, 12'h123, 8'h30);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        logic wb;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy after reset", busy, 1'b0);
        check("R1 rdata after reset", rdata, 8'h00);
        array_read("R1 erased content", 4'b0100, 12'h00A);

        // R3/R4/R6/R7 directed program, high address bits do not matter (R2)
        program_op(4'b0001, 12'hFF3, 8'h5A, 6);
        rd(4'b0001, 12'h003, v, wb);
        check("R3 programmed value", v, 8'h5A);
        rd(4'b0001, 12'h7A3, v2, wb);
        check("R7 two reads equal bit6", v2[6], v[6]);
        check("R2 sector index with low address bits", v2, 8'h5A);

        // R11 rdata holds without a read
        repeat (4) @(negedge clk);
        check("R11 rdata held", rdata, 8'h5A);

        // R3 AND-programming; writes during busy ignored (R10); unselected read (R2)
        busy_cnt = 0;
        wr(4'b0001, 12'h555, 8'hAA);
        wr(4'b0001, 12'h2AA, 8'h55);
        wr(4'b0001, 12'h555, 8'hA0);
        wr(4'b0001, 12'h003, 8'hF0);
        status_read("R4 R6 status bit7 one", 4'b0001, 1'b0);
        wr(4'b0010, 12'h555, 8'hAA);
        wr(4'b0010, 12'h2AA, 8'h55);
        wr(4'b0010, 12'h555, 8'hA0);
        wr(4'b0010, 12'h005, 8'h00);
        rd(4'b0000, 12'h0, v, wb);
        check("R2 unselected read leaves rdata", v, status_byte(1'b0, ~tog_m));
        status_read("R2 R6 toggle unchanged by unselected read", 4'b0001, 1'b0);
        wait_idle();
        check("R3 second program busy length", busy_cnt, PROG_CYC);
        model[3] = model[3] & 8'hF0;
        array_read("R3 AND result", 4'b0001, 12'h003);
        array_read("R10 write during busy ignored", 4'b0010, 12'h005);
        check("R10 no launch after busy", busy, 1'b0);

        // R9 broken sequences
        wr(4'b0001, 12'h555, 8'hAA);
        wr(4'b0001, 12'h2AA, 8'h55);
        wr(4'b0001, 12'h555, 8'h77);
        wr(4'b0001, 12'h008, 8'h00);
        @(negedge clk);
        check("R9 broken sequence no busy", busy, 1'b0);
        array_read("R9 broken sequence no change", 4'b0001, 12'h008);
        wr(4'b0001, 12'h555, 8'hAA);
        wr(4'b0001, 12'h2AA, 8'hF0);
        wr(4'b0001, 12'h555, 8'hA0);
        wr(4'b0001, 12'h009, 8'h00);
        @(negedge clk);
        check("R9 reset command aborts", busy, 1'b0);
        array_read("R9 reset command no change", 4'b0001, 12'h009);
        // R2 unselected sequence ignored
        wr(4'b0000, 12'h555, 8'hAA);
        wr(4'b0000, 12'h2AA, 8'h55);
        wr(4'b0000, 12'h555, 8'hA0);
        wr(4'b0000, 12'h00C, 8'h00);
        @(negedge clk);
        check("R2 unselected write ignored", busy, 1'b0);

        // program data into sectors 1 and 2 before erase
        program_op(4'b0010, 12'h001, 8'h12, 2);
        program_op(4'b0100, 12'h00E, 8'h34, 2);

        // R5 erase with sector 1 protected
        prot = 4'b0010;
        erase_seq(4'b1000);
        check("R5 busy after erase launch", busy, 1'b1);
        for (int i = 0; i < 5; i++) status_read("R5 R6 erase status", 4'b1000, 1'b0);
        wait_idle();
        check("R5 erase busy length", busy_cnt, ERASE_CYC);
        for (int i = 0; i < DEPTH; i++) if (!prot[i >> BYTE_AW]) model[i] = 8'hFF;
        array_read("R5 protected sector kept", 4'b0010, 12'h001);
        array_read("R5 unprotected sector erased", 4'b0100, 12'h00E);
        array_read("R5 sector0 erased", 4'b0001, 12'h003);

        // R8 all protected
        program_op(4'b0001, 12'h002, 8'h3C, 1);
        prot = '1;
        erase_seq(4'b0001);
        for (int i = 0; i < 3; i++) status_read("R8 refused erase status", 4'b0001, 1'b0);
        wait_idle();
        check("R8 refused erase busy length", busy_cnt, LOCK_CYC);
        array_read("R8 data unchanged", 4'b0001, 12'h002);
        array_read("R8 other data unchanged", 4'b0010, 12'h001);
        prot = '0;

        // constrained random programs and reads
        for (int it = 0; it < 40; it++) begin
            logic [NSECT-1:0] s;
            logic [11:0] a;
            logic [7:0] d;
            s = NSECT'(1) << ($urandom % NSECT);
            a = 12'($urandom);
            d = 8'($urandom);
            if ($urandom % 4 == 0) begin
                wr(s, 12'h555, 8'hAA);
                wr(s, 12'h2AA, 8'h55);
                wr(s, 12'h2AA, 8'hA0);
                @(negedge clk);
                check("R9 random broken sequence", busy, 1'b0);
            end
            program_op(s, a, d, 1 + ($urandom % 6));
            array_read("R3 random program readback", s, a);
            array_read("R7 random readback", NSECT'(1) << ($urandom % NSECT), 12'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule